// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one memory or I/O transfer at a time on a bus where the low address bits and the data word share the same pins. The core presents a request: a 20-bit address, a 16-bit write word, a flag saying whether the upper data byte takes part, an I/O-or-memory flag and a read-or-write flag. The block then steps through a fixed clock sequence. It puts the address on the shared lines for one clock and marks it with a latch strobe. It then turns the lines around to carry data. It moves the read or write strobe, the transceiver enable and the direction line at the right clocks, and it stretches the cycle while the target holds ready low.

The sequencer has six states. ST_IDLE waits for a request and moves to ST_T1 when `req_valid` is high. ST_T1 is the address clock and always moves to ST_T2. ST_T2 is the turnaround or first write-data clock and always moves to ST_T3. ST_T3 moves to ST_T4 when ready is sampled high, and otherwise to the wait state ST_TW. ST_TW stays in ST_TW while ready is low and moves to ST_T4 when it is high. ST_T4 is the closing clock: it presents read data with a one-clock done pulse and returns to ST_IDLE. The status code that replaces the upper address bits after the first clock lets an external observer see what kind of cycle is running.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: After reset and between cycles the block is idle: `ale` is 0, `bhe_n`, `rd_n`, `wr_n` and `den_n` are 1, `ad_oe` is 0 and `done` is 0.
- R2: In the first clock of a cycle (one clock after `req_valid` is seen while idle), `ale` is 1, `ad_oe` is 1, `ad_out` equals address bits 15:0 and `a_hi` equals address bits 19:16. `ale` is high for that clock only.
- R3: From the second clock to the last clock of a cycle, `a_hi` carries the status code: bit 3 is 1, bit 2 is the I/O flag, bit 1 is the write flag and bit 0 is the upper-byte flag.
- R4: `bhe_n` is 0 in the first clock exactly when the upper-byte flag of the request is 1. It is 1 in every other clock.
- R5: On reads `rd_n` is 0 in clock 2, clock 3 and every wait clock, and 1 otherwise. On writes `wr_n` follows the same timing. The strobe of the other direction stays 1.
- R6: For the whole cycle, `io_sel` is 1 for I/O cycles and 0 for memory cycles, and `dt_dir` is 1 for writes and 0 for reads.
- R7: `den_n` is 0 from clock 2 to the last clock on writes, and from clock 3 to the last clock on reads. It is 1 otherwise.
- R8: On writes the shared lines carry the write word with `ad_oe` = 1 from clock 2 to the last clock. On reads `ad_oe` is 0 after clock 1.
- R9: `ready` is sampled at the clock edge that ends clock 3 and at the edge that ends each wait clock. Each low sample inserts one wait clock before clock 4, so a cycle lasts 4 + n clocks.
- R10: On reads, `ad_in` is captured at the edge where ready is sampled high. `done` is 1 for the final clock only. In that clock `rd_data` holds the captured word, and it keeps that value until the next read.
- R11: `req_valid` and the request fields are ignored while a cycle is in progress. The running cycle's outputs keep the values of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a cycle; taken only when idle |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write word |
| req_hi | input | 1 | Upper data byte takes part |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| ready | input | 1 | Target ready; low inserts wait clocks |
| ad_in | input | 16 | Value seen on the shared lines |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Shared lines driven when 1, floating when 0 |
| a_hi | output | 4 | Upper address in clock 1, status code afterwards |
| ale | output | 1 | Address latch strobe |
| bhe_n | output | 1 | Upper byte enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | 1 = I/O, 0 = memory |
| dt_dir | output | 1 | 1 = transmit, 0 = receive |
| den_n | output | 1 | Transceiver enable, active low |
| rd_data | output | 16 | Captured read word |
| done | output | 1 | One-clock pulse in the final clock |

## Verification
The bench checks every output in every clock of reads and writes with zero, one and several wait clocks. A design that sampled ready one edge late or early would show up as a cycle of the wrong length, with the strobes and done shifted. Reads are checked for floating lines and a late transceiver enable, because a design that drove the bus on a read, or opened the transceiver in clock 2, would fight the target. A request raised in the middle of a cycle with different fields must leave the running cycle untouched, since a design that latched it would change the status code or the data word. Upper-byte enable is checked both on and off, and it must appear only in the address clock.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } bus_state_t;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       ready,
    output bus_state_t state,
    output logic       accept
);
    bus_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ready ? ST_T4 : ST_TW;
            ST_TW:   nxt = ready ? ST_T4 : ST_TW;
            ST_T4:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign accept = (state == ST_IDLE) && req_valid;
endmodule

// File: rtl/mbus_capture.sv
module mbus_capture
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  bus_state_t        state,
    input  logic              ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_hi,
    input  logic              req_io,
    input  logic              req_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              lat_hi,
    output logic              lat_io,
    output logic              lat_wr,
    output logic [DATA_W-1:0] rd_data
);
    logic data_edge;
    assign data_edge = ((state == ST_T3) || (state == ST_TW)) && ready && !lat_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_hi    <= 1'b0;
            lat_io    <= 1'b0;
            lat_wr    <= 1'b0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_hi    <= req_hi;
            lat_io    <= req_io;
            lat_wr    <= req_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_data <= '0;
        else if (data_edge) rd_data <= ad_in;
    end
endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  bus_state_t        state,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [DATA_W-1:0] lat_wdata,
    input  logic              lat_hi,
    input  logic              lat_io,
    input  logic              lat_wr,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic              ale,
    output logic              bhe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_sel,
    output logic              dt_dir,
    output logic              den_n,
    output logic              done
);
    logic [3:0]      code;
    logic [HI_W-1:0] stat;

    assign code = {1'b1, lat_io, lat_wr, lat_hi};

    for (genvar i = 0; i < HI_W; i++) begin : g_stat
        assign stat[i] = code[i % 4];
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        a_hi   = '0;
        ale    = 1'b0;
        bhe_n  = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        io_sel = 1'b0;
        dt_dir = 1'b1;
        den_n  = 1'b1;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = lat_addr[DATA_W-1:0];
                a_hi   = lat_addr[ADDR_W-1:DATA_W];
                bhe_n  = !lat_hi;
                io_sel = lat_io;
                dt_dir = lat_wr;
            end
            ST_T2, ST_T3, ST_TW, ST_T4: begin
                a_hi   = stat;
                io_sel = lat_io;
                dt_dir = lat_wr;
                if (lat_wr) begin
                    ad_oe  = 1'b1;
                    ad_out = lat_wdata;
                    den_n  = 1'b0;
                end else if (state != ST_T2) begin
                    den_n  = 1'b0;
                end
                if (state != ST_T4) begin
                    rd_n = lat_wr;
                    wr_n = !lat_wr;
                end
                done = (state == ST_T4);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_hi,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic              ale,
    output logic              bhe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_sel,
    output logic              dt_dir,
    output logic              den_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    bus_state_t        state;
    logic              accept;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_hi, lat_io, lat_wr;

    mbus_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
        .state(state), .accept(accept)
    );

    mbus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .accept(accept), .state(state), .ready(ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_hi(req_hi),
        .req_io(req_io), .req_write(req_write), .ad_in(ad_in),
        .lat_addr(lat_addr), .lat_wdata(lat_wdata), .lat_hi(lat_hi),
        .lat_io(lat_io), .lat_wr(lat_wr), .rd_data(rd_data)
    );

    mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
        .state(state), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
        .lat_hi(lat_hi), .lat_io(lat_io), .lat_wr(lat_wr),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
        .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel),
        .dt_dir(dt_dir), .den_n(den_n), .done(done)
    );
endmodule

// File: rtl/mbus_cycle_chk.sv
module mbus_cycle_chk (
    input logic clk,
    input logic rst_n,
    input logic ad_oe,
    input logic ale,
    input logic bhe_n,
    input logic rd_n,
    input logic wr_n,
    input logic dt_dir,
    input logic den_n,
    input logic done
);
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2
    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe && rd_n && wr_n && den_n); // R2
    AST_BHE_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !bhe_n |-> ale); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!rd_n, !wr_n})); // R5
    AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe && !dt_dir); // R8
    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe && dt_dir && !den_n); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !ale); // R10
    AST_DONE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_n && wr_n && !den_n); // R5
endmodule

bind mbus_cycle_ctrl mbus_cycle_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ad_oe(ad_oe), .ale(ale), .bhe_n(bhe_n),
    .rd_n(rd_n), .wr_n(wr_n), .dt_dir(dt_dir), .den_n(den_n), .done(done)
);

// File: tb/sim_mbus_cycle_ctrl.sv
module sim_mbus_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_hi = 1'b0, req_io = 1'b0, req_write = 1'b0;
    logic        ready = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out, rd_data;
    logic [3:0]  a_hi;
    logic        ad_oe, ale, bhe_n, rd_n, wr_n, io_sel, dt_dir, den_n, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mbus_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_hi(req_hi), .req_io(req_io),
        .req_write(req_write), .ready(ready), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .bhe_n(bhe_n), .rd_n(rd_n),
        .wr_n(wr_n), .io_sel(io_sel), .dt_dir(dt_dir), .den_n(den_n),
        .rd_data(rd_data), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk("R1", {tag, " ale"}, ale, 0);
        chk("R1", {tag, " strobes"}, {bhe_n, rd_n, wr_n, den_n}, 4'hF);
        chk("R1", {tag, " ad_oe"}, ad_oe, 0);
        chk("R1", {tag, " done"}, done, 0);
    endtask

    // Runs one cycle; bench is at a negedge while idle on entry and exit.
    task automatic run_cycle(input logic [19:0] addr, input logic [15:0] wd,
                             input logic hi, input logic io, input logic wr,
                             input int nwait, input logic [15:0] rv,
                             input bit disturb);
        int last;
        logic [3:0] st;
        last = 4 + nwait;
        st = {1'b1, io, wr, hi};
        req_addr = addr; req_wdata = wd; req_hi = hi; req_io = io;
        req_write = wr; req_valid = 1'b1; ad_in = rv;
        @(posedge clk); @(negedge clk);
        if (disturb) begin // R11: new request fields mid-cycle
            req_addr = ~addr; req_wdata = ~wd; req_hi = !hi;
            req_io = !io; req_write = !wr;
        end else begin
            req_valid = 1'b0;
        end
        for (int c = 1; c <= last; c++) begin
            chk("R2", "ale", ale, c == 1);
            if (c == 1) begin
                chk("R2", "ad_out addr", ad_out, addr[15:0]);
                chk("R2", "a_hi addr", a_hi, addr[19:16]);
                chk("R2", "ad_oe addr", ad_oe, 1);
            end else begin
                chk(disturb ? "R11" : "R3", "a_hi status", a_hi, st);
                chk("R8", "ad_oe data", ad_oe, wr);
                if (wr) chk(disturb ? "R11" : "R8", "write word", ad_out, wd);
            end
            chk("R4", "bhe_n", bhe_n, !(c == 1 && hi));
            chk("R5", "rd_n", rd_n, !(!wr && c >= 2 && c < last));
            chk("R5", "wr_n", wr_n, !(wr && c >= 2 && c < last));
            chk("R6", "io_sel", io_sel, io);
            chk("R6", "dt_dir", dt_dir, wr);
            chk("R7", "den_n", den_n, !(wr ? c >= 2 : c >= 3));
            chk("R9", "done timing", done, c == last);
            if (c == last && !wr) chk("R10", "rd_data", rd_data, rv);
            if (c >= 3) ready = (c >= 3 + nwait); // R9: sampled at end of clock 3 and waits
            if (c >= 3) ad_in = (c >= 3 + nwait) ? rv : ~rv;
            if (c == last) req_valid = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        ready = 1'b1;
        chk_idle("after cycle");
        if (!wr) chk("R10", "rd_data held", rd_data, rv);
    endtask

    task automatic t_reset;
        chk_idle("reset");
        chk("R10", "rd_data reset", rd_data, 0);
    endtask

    task automatic t_read_nowait;
        run_cycle(20'hA1234, 16'h0000, 1'b1, 1'b0, 1'b0, 0, 16'hBEEF, 0);
    endtask

    task automatic t_write_nowait;
        run_cycle(20'h5F00D, 16'hC0DE, 1'b0, 1'b1, 1'b1, 0, 16'h0000, 0);
    endtask

    task automatic t_read_waits;
        run_cycle(20'h3000F, 16'h0000, 1'b0, 1'b1, 1'b0, 3, 16'h1357, 0);
    endtask

    task automatic t_write_wait1;
        run_cycle(20'hFFFFE, 16'h8421, 1'b1, 1'b0, 1'b1, 1, 16'h0000, 0);
    endtask

    task automatic t_ignore_midcycle;
        run_cycle(20'h7ABCD, 16'h55AA, 1'b1, 1'b1, 1'b1, 2, 16'h0000, 1);
        run_cycle(20'h02468, 16'h0000, 1'b0, 1'b0, 1'b0, 0, 16'h9ABC, 1);
    endtask

    task automatic t_idle_gap;
        repeat (3) @(negedge clk);
        chk_idle("gap");
        chk("R10", "rd_data kept", rd_data, 16'h9ABC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_nowait();
        t_write_nowait();
        t_read_waits();
        t_write_wait1();
        t_ignore_midcycle();
        t_idle_gap();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule